// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit buses, called A and B. Each bus is modelled as separate input, output and output-enable signals. Each transfer direction has its own storage register, its own capture strobe, its own output enable and its own source select. The value driven onto a bus comes from one of two places: the live input of the opposite bus, passed straight through with no register in the path, or the value held in that direction's storage register. A capture strobe loads its register from the opposite bus on each rising edge, whatever the enables and selects are doing.

The capture strobes, selects and enables are all sampled on one system clock. A strobe edge is detected by comparing the strobe with its value in the previous cycle. Each select is registered, so the output source changes only at a clock edge and no mixed value appears while the source is being switched.

When both directions are enabled and both selects ask for live data, the two buses form a loop in which each reinforces the other. A keeper register breaks that combinational loop and drives both buses. It loads from whichever bus another agent is actively driving, as shown by a drive-valid strobe on each bus, and otherwise holds its last value.

Top module: `regbus_xcvr`

## Requirements
- R1: While `rst` is high at a clock edge, both storage registers and the keeper clear to zero and both `a_oe` and `b_oe` go low after that edge.
- R2: When `cap_ab` is high at a clock edge and was low at the edge before, the A-to-B register loads `a_in`. The same rule applies to `cap_ba`, which loads `b_in` into the B-to-A register. With stored mode selected, the new value appears on the driven output after that edge.
- R3: Capture happens regardless of the enables and selects. A value captured while a direction is disabled and in live mode is the value later shown when that direction is enabled in stored mode.
- R4: A storage register keeps its value while its strobe stays high or falls, and between rising edges, however `a_in` or `b_in` change.
- R5: With the registered select low (live), `b_out` equals `a_in` and `a_out` equals `b_in` within the same cycle, with no added clock latency.
- R6: A change on `sel_ab` or `sel_ba` takes effect only at the next clock edge. Between edges the output keeps its previous source (select high = stored, low = live).
- R7: `b_oe` follows the active-high `oe_ab` one clock later. `a_oe` follows the inverse of the active-low `oe_ba_n` one clock later.
- R8: When both outputs are enabled and both registered selects are low, `a_out` and `b_out` both show the keeper. At each edge the keeper loads `a_in` if `a_drv_vld` is high, otherwise `b_in` if `b_drv_vld` is high, otherwise it holds its value.
- R9: The keeper follows the drive-valid strobes outside loop mode too, so entering loop mode with no bus driven presents the last value that was driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 8 | Value seen on bus A |
| a_drv_vld | input | 1 | Another agent is driving bus A this cycle |
| b_in | input | 8 | Value seen on bus B |
| b_drv_vld | input | 1 | Another agent is driving bus B this cycle |
| cap_ab | input | 1 | Capture strobe: rising edge stores bus A |
| cap_ba | input | 1 | Capture strobe: rising edge stores bus B |
| oe_ab | input | 1 | Active-high enable for driving bus B |
| oe_ba_n | input | 1 | Active-low enable for driving bus A |
| sel_ab | input | 1 | Bus B source: 0 live bus A, 1 stored |
| sel_ba | input | 1 | Bus A source: 0 live bus B, 1 stored |
| a_out | output | 8 | Value driven onto bus A |
| a_oe | output | 1 | Bus A output enable |
| b_out | output | 8 | Value driven onto bus B |
| b_oe | output | 1 | Bus B output enable |

## Verification
The assertions assume that every control input is synchronous to `clk`. In particular, each capture strobe and drive-valid strobe must hold its level for at least one whole cycle, so that an edge is seen as a level change between two clock samples. The stimulus changes every input only at the falling clock edge and holds it until the next falling edge, so each strobe rise spans a complete cycle. The bench samples once just after the falling edge, to see the live path and the previous source, and once just after the rising edge, to see registered effects.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned XCVR_W = 8;

  typedef enum logic [1:0] {
    SRC_OFF    = 2'd0,
    SRC_LIVE   = 2'd1,
    SRC_STORED = 2'd2,
    SRC_HOLD   = 2'd3
  } src_e;
endpackage

// File: rtl/xcvr_cap_reg.sv
module xcvr_cap_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic strobe_q;
  logic rise;

  assign rise = strobe & ~strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      q        <= '0;
    end else begin
      strobe_q <= strobe;
      if (rise) q <= din;
    end
  end

  // R2: a detected rising edge loads the opposite bus
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    rise |=> (q == $past(din)));

  // R4: no rising edge, no change of stored contents
  p_keep_r4: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(q));
endmodule

// File: rtl/xcvr_sel_path.sv
module xcvr_sel_path #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic         sel_q,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst) sel_q <= 1'b0;
    else     sel_q <= sel;
  end

  assign dout = sel_q ? stored : live;

  // R6: the source in use is the select seen at the previous edge
  p_sel_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (sel_q == $past(sel)));
endmodule

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         a_vld,
  input  logic [W-1:0] a_d,
  input  logic         b_vld,
  input  logic [W-1:0] b_d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (a_vld) q <= a_d;
    else if (b_vld) q <= b_d;
  end

  // R8: bus A wins when both buses are driven
  p_prio_r8: assert property (@(posedge clk) disable iff (rst)
    a_vld |=> (q == $past(a_d)));

  // R9: with no bus driven the keeper holds
  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!a_vld && !b_vld) |=> $stable(q));
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic         a_drv_vld,
  input  logic [W-1:0] b_in,
  input  logic         b_drv_vld,
  input  logic         cap_ab,
  input  logic         cap_ba,
  input  logic         oe_ab,
  input  logic         oe_ba_n,
  input  logic         sel_ab,
  input  logic         sel_ba,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  logic [W-1:0] store_ab, store_ba, path_b, path_a, hold_q;
  logic         sel_ab_q, sel_ba_q;
  logic         en_b_q, en_a_q;
  logic         loop_mode;
  src_e         src_b, src_a;

  xcvr_cap_reg #(.W(W)) u_cap_ab (
    .clk(clk), .rst(rst), .strobe(cap_ab), .din(a_in), .q(store_ab));
  xcvr_cap_reg #(.W(W)) u_cap_ba (
    .clk(clk), .rst(rst), .strobe(cap_ba), .din(b_in), .q(store_ba));

  xcvr_sel_path #(.W(W)) u_path_b (
    .clk(clk), .rst(rst), .sel(sel_ab), .live(a_in), .stored(store_ab),
    .sel_q(sel_ab_q), .dout(path_b));
  xcvr_sel_path #(.W(W)) u_path_a (
    .clk(clk), .rst(rst), .sel(sel_ba), .live(b_in), .stored(store_ba),
    .sel_q(sel_ba_q), .dout(path_a));

  xcvr_keeper #(.W(W)) u_keep (
    .clk(clk), .rst(rst), .a_vld(a_drv_vld), .a_d(a_in),
    .b_vld(b_drv_vld), .b_d(b_in), .q(hold_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_b_q <= 1'b0;
      en_a_q <= 1'b0;
    end else begin
      en_b_q <= oe_ab;
      en_a_q <= ~oe_ba_n;
    end
  end

  assign loop_mode = en_b_q & en_a_q & ~sel_ab_q & ~sel_ba_q;

  always_comb begin
    if (!en_b_q)        src_b = SRC_OFF;
    else if (loop_mode) src_b = SRC_HOLD;
    else if (sel_ab_q)  src_b = SRC_STORED;
    else                src_b = SRC_LIVE;
    if (!en_a_q)        src_a = SRC_OFF;
    else if (loop_mode) src_a = SRC_HOLD;
    else if (sel_ba_q)  src_a = SRC_STORED;
    else                src_a = SRC_LIVE;
  end

  always_comb begin
    case (src_b)
      SRC_HOLD:            b_out = hold_q;
      SRC_LIVE, SRC_STORED: b_out = path_b;
      default:             b_out = '0;
    endcase
    case (src_a)
      SRC_HOLD:            a_out = hold_q;
      SRC_LIVE, SRC_STORED: a_out = path_a;
      default:             a_out = '0;
    endcase
  end

  assign b_oe = en_b_q;
  assign a_oe = en_a_q;

  // R7: enables follow their inputs one cycle later, with polarity
  p_oe_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((b_oe == $past(oe_ab)) && (a_oe == !$past(oe_ba_n))));

  // R8: in loop mode both buses carry the same value
  p_loop_r8: assert property (@(posedge clk) disable iff (rst)
    (a_oe && b_oe && !sel_ab_q && !sel_ba_q) |-> (a_out == b_out));
endmodule

// File: tb/tb_regbus_xcvr.sv
`timescale 1ns/100ps
module tb_regbus_xcvr;
  localparam int W = 8;

  typedef struct {
    logic         a_oe, b_oe;
    logic [W-1:0] a_out, b_out;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic a_drv_vld = 0, b_drv_vld = 0, cap_ab = 0, cap_ba = 0;
  logic oe_ab = 0, oe_ba_n = 1, sel_ab = 0, sel_ba = 0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;

  always #2.5 clk = ~clk;

  regbus_xcvr #(.W(W)) dut (
    .clk(clk), .rst(rst), .a_in(a_in), .a_drv_vld(a_drv_vld),
    .b_in(b_in), .b_drv_vld(b_drv_vld), .cap_ab(cap_ab), .cap_ba(cap_ba),
    .oe_ab(oe_ab), .oe_ba_n(oe_ba_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe));

  int errors = 0;
  int checks = 0;
  exp_t sb[$];

  // bench-side model state (meaning taken from the requirements)
  logic [W-1:0] m_rab = '0, m_rba = '0, m_hold = '0;
  logic m_sab = 0, m_sba = 0, m_eb = 0, m_ea = 0, m_cab = 0, m_cba = 0;

  // next-cycle stimulus, set by the sequence before each step
  logic [W-1:0] n_a = '0, n_b = '0;
  logic n_rst = 1, n_av = 0, n_bv = 0, n_cab = 0, n_cba = 0;
  logic n_oab = 0, n_oban = 1, n_sab = 0, n_sba = 0;

  function automatic exp_t predict(string tag);
    exp_t e;
    logic loop;
    loop = m_eb & m_ea & ~m_sab & ~m_sba;
    e.tag  = tag;
    e.b_oe = m_eb;
    e.a_oe = m_ea;
    e.b_out = loop ? m_hold : (m_sab ? m_rab : n_a);
    e.a_out = loop ? m_hold : (m_sba ? m_rba : n_b);
    return e;
  endfunction

  task automatic compare(exp_t e, string when);
    checks++;
    if (a_oe !== e.a_oe || b_oe !== e.b_oe ||
        (e.b_oe && b_out !== e.b_out) || (e.a_oe && a_out !== e.a_out)) begin
      errors++;
      $display("FAIL %s (%s): got a_oe=%b b_oe=%b a_out=%h b_out=%h exp a_oe=%b b_oe=%b a_out=%h b_out=%h",
               e.tag, when, a_oe, b_oe, a_out, b_out,
               e.a_oe, e.b_oe, e.a_out, e.b_out);
    end
  endtask

  // driver: apply inputs at the falling edge, check the mid-cycle view,
  // advance the model to the next rising edge and queue its prediction
  task automatic step(string tag);
    exp_t mid;
    @(negedge clk);
    rst = n_rst; a_in = n_a; b_in = n_b; a_drv_vld = n_av; b_drv_vld = n_bv;
    cap_ab = n_cab; cap_ba = n_cba; oe_ab = n_oab; oe_ba_n = n_oban;
    sel_ab = n_sab; sel_ba = n_sba;
    #1;
    if (!n_rst) begin
      mid = predict(tag);
      compare(mid, "mid-cycle");
    end
    if (n_rst) begin
      m_rab = '0; m_rba = '0; m_hold = '0; m_sab = 0; m_sba = 0;
      m_eb = 0; m_ea = 0; m_cab = 0; m_cba = 0;
    end else begin
      if (n_cab && !m_cab) m_rab = n_a;
      if (n_cba && !m_cba) m_rba = n_b;
      m_cab = n_cab; m_cba = n_cba;
      if (n_av)      m_hold = n_a;
      else if (n_bv) m_hold = n_b;
      m_sab = n_sab; m_sba = n_sba;
      m_eb = n_oab;  m_ea = ~n_oban;
    end
    sb.push_back(predict(tag));
    @(posedge clk);
  endtask

  // monitor: pop and compare just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) compare(sb.pop_front(), "post-edge");
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset clears enables, registers and keeper
    n_rst = 1; step("R1"); step("R1");
    n_rst = 0; n_oab = 1; n_oban = 0; n_sab = 1; n_sba = 1;
    step("R1 stored zero");
    // R2: rising strobes capture
    n_a = 8'h5A; n_cab = 1; step("R2 capture A");
    n_cab = 0; step("R2");
    n_b = 8'hC3; n_cba = 1; step("R2 capture B");
    n_cba = 0; step("R2");
    // R4: held or falling strobe does not capture
    n_a = 8'h11; n_cab = 1; step("R4 rise");
    n_a = 8'h22; step("R4 held high");
    n_a = 8'h33; n_cab = 0; step("R4 fall");
    n_a = 8'h44; step("R4 low");
    // R3: capture while disabled and live
    n_oab = 0; n_sab = 0; n_a = 8'h77; n_cab = 1; step("R3 disabled");
    n_cab = 0; n_a = 8'h00; step("R3");
    n_oab = 1; n_sab = 1; step("R3 shown");
    // R5: live pass-through, several patterns
    n_sab = 0; n_sba = 0; n_oban = 1; step("R6 switch to live");
    n_a = 8'hA0; step("R5 live");
    n_a = 8'h0F; step("R5 live");
    n_a = 8'hFF; step("R5 live");
    n_oab = 0; n_oban = 0; n_b = 8'h96; step("R5 live B");
    n_b = 8'h69; step("R5 live B");
    // R6: switching back to stored waits for the edge
    n_sba = 1; n_b = 8'h12; step("R6 to stored");
    n_sba = 0; step("R6 to live");
    // R7: enable polarity and latency
    n_oab = 1; n_oban = 1; n_sab = 1; step("R7");
    n_oab = 0; n_oban = 0; step("R7");
    n_oab = 1; n_oban = 1; step("R7");
    // R8: loop mode with keeper
    n_oab = 1; n_oban = 0; n_sab = 0; n_sba = 0;
    n_av = 1; n_a = 8'hA5; step("R8 A drives");
    n_av = 0; n_a = 8'hFF; n_b = 8'hEE; step("R8 hold");
    n_bv = 1; n_b = 8'h3C; step("R8 B drives");
    n_av = 1; n_a = 8'h11; n_b = 8'h22; step("R8 A priority");
    n_av = 0; n_bv = 0; n_a = 8'h00; n_b = 8'h00; step("R8 hold");
    // R9: keeper tracks outside loop mode
    n_sab = 1; n_av = 1; n_a = 8'h66; step("R9 outside loop");
    n_av = 0; n_a = 8'h01; step("R9");
    n_sab = 0; step("R9 reenter loop");
    step("R9 held");
    @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule